// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer with Pulse Accumulator

This block is a general-purpose timer. A single 16-bit up-counter advances on ticks from a power-of-two prescaler. Four channels observe that counter. Each channel works on its own in one of two modes. In capture mode it records the counter when its pin shows a chosen edge. In compare mode it drives its output pin when the counter steps onto the channel's stored value. When the counter wraps it sets a sticky flag, so software can count wraps and measure times longer than 16 bits.

Channel 3 can instead drive a 16-bit pulse accumulator. In event mode the accumulator counts pin edges. In gated mode it counts fixed 64-cycle time units while the pin is at its active level. All registers sit behind a simple write/read port. Every pin input passes through a two-flop synchronizer before any edge detection.

Top module: `quad_timer`

## Requirements
- R1: After reset the counter, accumulator, all channel outputs and all flags are zero.
- R2: Control register (address 0) bit 0 runs the counter and bits [3:1] select the divider 2^sel (1 to 128). After the run bit is written to 1 with the counter at zero, the counter reads k>>sel after k further clock cycles. With the run bit at 0 the counter holds its value.
- R3: When the counter steps from FFFF to 0000, the overflow flag (flags register, address 3, bit 4) is set.
- R4: Mode register (address 1) bit i at 0 selects capture for channel i. The field at bits [5+2i:4+2i] picks the edge: 01 rising, 10 falling, 11 either, 00 none. On the chosen pin edge the counter value is latched into the channel register (address 8+i) and flag bit i is set. A pin change made just before clock edge a (counted from the start of the counter) captures (a+2)>>sel. An unselected edge changes neither the register nor the flag.
- R5: Mode bit i at 1 selects compare. On the tick where the counter steps onto the channel value, the output pin is toggled (field 01), cleared (10) or set (11), and flag bit i is set. Before that tick the output and the flag are unchanged.
- R6: Control bit 4 turns channel 3 into the accumulator input and disables capture and compare on channel 3. With control bit 5 at 0 (event mode) the accumulator (address 4) counts rising edges when control bit 6 is 1. Each counted edge sets flag bit 6.
- R7: With control bits 4 and 5 both at 1 (gated mode) and the run bit set, the accumulator adds one on every 64th clock while pin 3 is at the level given by control bit 6. When the gate closes, flag bit 6 is set.
- R8: When the accumulator steps from FFFF to 0000, flag bit 5 is set.
- R9: Writing address 2 loads the counter, and this load takes priority over a prescaler tick in the same cycle.
- R10: Flags are cleared by writing 1 to their bit in address 3. A flag that is set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ch_pin | input | 4 | Channel input pins (asynchronous) |
| ch_out | output | 4 | Compare output pins |
| ch_flag | output | 4 | Per-channel event flags |
| ovf_flag | output | 1 | Counter wrap flag |
| pa_ovf_flag | output | 1 | Accumulator wrap flag |
| pa_evt_flag | output | 1 | Accumulator edge / gate-closed flag |

## Verification
A counter wrap and a software clear of the overflow flag can land on the same clock edge. The bench loads the counter with FFFD, then times a write-one-to-clear of flag bit 4 so that it takes effect on exactly the wrap edge. It expects the flag to read as set after that edge, and clear only after a second, lone clear. A counter load that lands in the same cycle as a running tick is judged the same way: the loaded value must win. Random prescaler settings, compare values and capture edges are checked against bench-side arithmetic of the tick and synchronizer timing.

// File: rtl/quad_timer.sv
`timescale 1ns/1ps
module quad_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [3:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic [3:0]    ch_pin,
  output logic [3:0]    ch_out,
  output logic [3:0]    ch_flag,
  output logic          ovf_flag,
  output logic          pa_ovf_flag,
  output logic          pa_evt_flag
);
  logic [6:0]    ctrl;
  logic [11:0]   mode;
  logic [CW-1:0] cnt, pacc;
  logic [CW-1:0] chv [4];
  logic [6:0]    presc;
  logic [3:0]    s1, s2, s3;

  wire       run     = ctrl[0];
  wire [2:0] sel     = ctrl[3:1];
  wire       pa_en   = ctrl[4];
  wire       pa_gate = ctrl[5];
  wire       pa_pol  = ctrl[6];

  wire [6:0]    mask   = 7'((8'd1 << sel) - 8'd1);
  wire          tick   = run && ((presc & mask) == mask);
  wire          tick64 = run && (presc[5:0] == 6'h3f);
  wire [CW-1:0] nxt    = cnt + 1'b1;
  wire [3:0]    rise   = s2 & ~s3;
  wire [3:0]    fall   = ~s2 & s3;

  wire we_ctrl = wr_en && wr_addr == 4'd0;
  wire we_mode = wr_en && wr_addr == 4'd1;
  wire we_cnt  = wr_en && wr_addr == 4'd2;
  wire we_flag = wr_en && wr_addr == 4'd3;
  wire we_pacc = wr_en && wr_addr == 4'd4;
  wire [6:0] clr = we_flag ? wr_data[6:0] : 7'd0;

  wire pa_inc  = pa_en && (pa_gate ? (tick64 && (s2[3] == pa_pol))
                                   : (pa_pol ? rise[3] : fall[3]));
  wire pa_done = pa_en && (pa_gate ? (pa_pol ? fall[3] : rise[3]) : pa_inc);

  logic [3:0] cap_hit, cmp_hit;
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      logic live;
      logic [1:0] f;
      live = !(i == 3 && pa_en);
      f = mode[4+2*i +: 2];
      cap_hit[i] = live && !mode[i] && ((f[0] && rise[i]) || (f[1] && fall[i]));
      cmp_hit[i] = live && mode[i] && tick && !we_cnt && (chv[i] == nxt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= ch_pin; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; mode <= '0; presc <= '0; cnt <= '0; pacc <= '0;
      ovf_flag <= 1'b0; pa_ovf_flag <= 1'b0; pa_evt_flag <= 1'b0;
    end else begin
      if (we_ctrl) ctrl <= wr_data[6:0];
      if (we_mode) mode <= wr_data[11:0];
      presc <= run ? presc + 7'd1 : 7'd0;
      if (we_cnt) cnt <= wr_data;
      else if (tick) cnt <= nxt;
      if (we_pacc) pacc <= wr_data;
      else if (pa_inc) pacc <= pacc + 1'b1;
      ovf_flag    <= (ovf_flag & ~clr[4]) | (tick && !we_cnt && &cnt);
      pa_ovf_flag <= (pa_ovf_flag & ~clr[5]) | (pa_inc && !we_pacc && &pacc);
      pa_evt_flag <= (pa_evt_flag & ~clr[6]) | pa_done;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_out <= '0; ch_flag <= '0;
      for (int i = 0; i < 4; i++) chv[i] <= '0;
    end else begin
      ch_flag <= (ch_flag & ~clr[3:0]) | cap_hit | cmp_hit;
      for (int i = 0; i < 4; i++) begin
        if (wr_en && wr_addr == 4'(8 + i)) chv[i] <= wr_data;
        if (cap_hit[i]) chv[i] <= cnt;
        if (cmp_hit[i])
          case (mode[4+2*i +: 2])
            2'b01:   ch_out[i] <= ~ch_out[i];
            2'b10:   ch_out[i] <= 1'b0;
            2'b11:   ch_out[i] <= 1'b1;
            default: ch_out[i] <= ch_out[i];
          endcase
      end
    end
  end

  always_comb begin
    if (rd_addr[3]) rd_data = chv[rd_addr[1:0]];
    else
      case (rd_addr[2:0])
        3'd0:    rd_data = CW'(ctrl);
        3'd1:    rd_data = CW'(mode);
        3'd2:    rd_data = cnt;
        3'd3:    rd_data = CW'({pa_evt_flag, pa_ovf_flag, ovf_flag, ch_flag});
        3'd4:    rd_data = pacc;
        default: rd_data = '0;
      endcase
  end
endmodule

// File: rtl/quad_timer_chk.sv
`timescale 1ns/1ps
module quad_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [3:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] pacc,
  input logic          tick,
  input logic          run,
  input logic [3:0]    ch_out,
  input logic [3:0]    ch_flag,
  input logic          ovf_flag,
  input logic          pa_ovf_flag
);
  wire ld  = wr_en && wr_addr == 4'd2;
  wire fwr = wr_en && wr_addr == 4'd3;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt)); // R2
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && cnt == '1) |=> ovf_flag); // R3
  AST_OUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_out != $past(ch_out)) |-> ((ch_flag & (ch_out ^ $past(ch_out))) == (ch_out ^ $past(ch_out)))); // R5
  AST_PA_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_ovf_flag) |-> ($past(pacc) == '1)); // R8
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(wr_data))); // R9
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwr && |ch_flag) |=> ((ch_flag & $past(ch_flag)) == $past(ch_flag))); // R10
endmodule

bind quad_timer quad_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt(cnt), .pacc(pacc), .tick(tick), .run(run), .ch_out(ch_out),
  .ch_flag(ch_flag), .ovf_flag(ovf_flag), .pa_ovf_flag(pa_ovf_flag)
);

// File: tb/sim_quad_timer.sv
`timescale 1ns/1ps
module sim_quad_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [3:0] ch_pin = '0, ch_out, ch_flag;
  logic ovf_flag, pa_ovf_flag, pa_evt_flag;

  always #2.5 clk = ~clk;

  quad_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ch_pin(ch_pin), .ch_out(ch_out),
    .ch_flag(ch_flag), .ovf_flag(ovf_flag), .pa_ovf_flag(pa_ovf_flag),
    .pa_evt_flag(pa_evt_flag)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [3:0] exp_out = '0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] ctl(int s, bit run, bit pa, bit gate, bit pol);
    return 16'(int'(run) | (s << 1) | (int'(pa) << 4) | (int'(gate) << 5) | (int'(pol) << 6));
  endfunction

  function automatic logic [15:0] cnt_after(int k, int s);
    return 16'(k >> s);
  endfunction

  function automatic logic cmp_result(logic old, int act);
    return (act == 1) ? ~old : (act == 2) ? 1'b0 : 1'b1;
  endfunction

  task automatic start(input int s);
    wr(0, 16'h0); wr(2, 16'h0); wr(0, ctl(s, 1, 0, 0, 0));
  endtask

  task automatic pulse3();
    ch_pin[3] = 1'b1; wait_n(3); ch_pin[3] = 1'b0; wait_n(3);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    wait_n(4); rst_n = 1'b1; wait_n(2);

    // R1 reset state
    rd(2, v); chk("R1 counter", v, 16'h0);
    rd(4, v); chk("R1 accumulator", v, 16'h0);
    rd(3, v); chk("R1 flags", v, 16'h0);
    chk("R1 outputs", 16'(ch_out), 16'h0);

    // R2 prescaled counting and hold
    for (int it = 0; it < 6; it++) begin
      int s, k;
      s = (it == 0) ? 7 : $urandom % 8;
      k = 1 + $urandom % 300;
      start(s);
      wait_n(k);
      rd(2, v); chk($sformatf("R2 count sel=%0d k=%0d", s, k), v, cnt_after(k, s));
      wr(0, ctl(s, 0, 0, 0, 0));
      rd(2, v);
      wait_n(10);
      begin logic [15:0] v2; rd(2, v2); chk("R2 hold while stopped", v2, v); end
    end

    // R9 load while running
    start(0);
    wr(2, 16'h1234);
    rd(2, v); chk("R9 load wins over tick", v, 16'h1234);
    wait_n(3);
    rd(2, v); chk("R9 count after load", v, 16'h1237);

    // R3 wrap
    wr(3, 16'h7f);
    wr(2, 16'hFFFE);
    chk("R3 no flag before wrap", 16'(ovf_flag), 16'h0);
    wait_n(1);
    rd(2, v); chk("R3 at FFFF", v, 16'hFFFF);
    wait_n(1);
    rd(2, v); chk("R3 wrapped", v, 16'h0);
    chk("R3 flag set", 16'(ovf_flag), 16'h1);

    // R10 set and clear in the same cycle: set wins
    wr(2, 16'hFFFD);
    wait_n(1);
    wr(3, 16'h10);
    chk("R10 R3 set beats clear", 16'(ovf_flag), 16'h1);
    wr(3, 16'h10);
    chk("R10 clear alone", 16'(ovf_flag), 16'h0);

    // R5 compare actions
    wr(0, 16'h0);
    for (int it = 0; it < 8; it++) begin
      int s, val, act, ch;
      s = $urandom % 3; val = 2 + $urandom % 30; act = 1 + $urandom % 3; ch = $urandom % 3;
      wr(0, 16'h0);
      wr(1, 16'((1 << ch) | (act << (4 + 2 * ch))));
      wr(4'(8 + ch), 16'(val));
      wr(3, 16'h7f);
      start(s);
      wait_n((val << s) - 1);
      chk($sformatf("R5 ch%0d no flag before match", ch), 16'(ch_flag[ch]), 16'h0);
      chk($sformatf("R5 ch%0d out before match", ch), 16'(ch_out), 16'(exp_out));
      wait_n(1);
      exp_out[ch] = cmp_result(exp_out[ch], act);
      chk($sformatf("R5 ch%0d flag at match", ch), 16'(ch_flag[ch]), 16'h1);
      chk($sformatf("R5 ch%0d out act=%0d", ch, act), 16'(ch_out), 16'(exp_out));
    end

    // R4 capture on selected edges
    for (int it = 0; it < 6; it++) begin
      int s, a, e, ch;
      logic pre;
      s = $urandom % 3; a = 3 + $urandom % 40; e = 1 + $urandom % 3; ch = $urandom % 3;
      pre = (e == 1) ? 1'b0 : (e == 2) ? 1'b1 : 1'($urandom % 2);
      wr(0, 16'h0);
      wr(1, 16'h0);
      ch_pin[ch] = pre;
      wait_n(4);
      wr(1, 16'(e << (4 + 2 * ch)));
      wr(3, 16'h7f);
      start(s);
      wait_n(a);
      ch_pin[ch] = ~pre;
      wait_n(2);
      chk($sformatf("R4 ch%0d flag not yet", ch), 16'(ch_flag[ch]), 16'h0);
      wait_n(1);
      chk($sformatf("R4 ch%0d flag", ch), 16'(ch_flag[ch]), 16'h1);
      rd(4'(8 + ch), v);
      chk($sformatf("R4 ch%0d captured a=%0d sel=%0d", ch, a, s), v, 16'((a + 2) >> s));
    end

    // R4 unselected edge ignored
    wr(0, 16'h0); wr(1, 16'h0);
    ch_pin = 4'b0001; wait_n(4);
    wr(8, 16'h5555);
    wr(1, 16'h0010);
    wr(3, 16'h7f);
    start(0);
    ch_pin[0] = 1'b0;
    wait_n(6);
    chk("R4 falling edge ignored flag", 16'(ch_flag[0]), 16'h0);
    rd(8, v); chk("R4 falling edge ignored reg", v, 16'h5555);

    // R6 event accumulator, channel 3 capture suppressed
    ch_pin = '0;
    wr(0, 16'h0);
    wr(1, 16'h0C00);
    wr(11, 16'hABCD);
    wr(4, 16'h0);
    wait_n(4);
    wr(3, 16'h7f);
    wr(0, ctl(0, 1, 1, 0, 1));
    begin
      int n;
      n = 5 + $urandom % 10;
      for (int p = 0; p < n; p++) pulse3();
      wait_n(4);
      rd(4, v); chk("R6 event count", v, 16'(n));
    end
    chk("R6 ch3 flag suppressed", 16'(ch_flag[3]), 16'h0);
    rd(11, v); chk("R6 ch3 reg untouched", v, 16'hABCD);
    chk("R6 event flag", 16'(pa_evt_flag), 16'h1);

    // R8 accumulator wrap
    wr(4, 16'hFFFF);
    wr(3, 16'h7f);
    pulse3(); wait_n(4);
    rd(4, v); chk("R8 accumulator wrapped", v, 16'h0);
    chk("R8 wrap flag", 16'(pa_ovf_flag), 16'h1);

    // R7 gated accumulation
    wr(0, ctl(0, 1, 1, 1, 1));
    wr(4, 16'h0);
    wr(3, 16'h7f);
    ch_pin[3] = 1'b1;
    wait_n(320);
    chk("R7 no gate flag while open", 16'(pa_evt_flag), 16'h0);
    wait_n(320);
    ch_pin[3] = 1'b0;
    wait_n(5);
    rd(4, v); chk("R7 gated units for 640 cycles", v, 16'd10);
    chk("R7 gate closed flag", 16'(pa_evt_flag), 16'h1);

    finished = 1;
    report();
  end
endmodule